// File: doc/BRIEF.md
# Multicycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a small load/store processor in which each instruction takes several clock cycles. One ALU does every arithmetic job: the PC increment, the branch target, address generation and register-to-register arithmetic. One memory array holds both the program and its data. Values that must carry from one cycle to the next sit in internal registers: the instruction register, a memory data register, two operand registers (A and B) and an ALU result register. Apart from the instruction register and the PC, these reload on every clock.

An external control sequencer drives every steering and enable input, one cycle at a time. The datapath gives back the opcode field of the held instruction and a zero flag from the ALU. It also shows the PC and the ALU result register so that the sequencer can follow progress. The supported instructions are R-type arithmetic, word load, word store, branch-if-equal and jump. The memory comes out of reset holding a program image passed in as a parameter.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held, the PC, the instruction register and the ALU result register become zero, every register-file entry becomes zero, and memory word i takes INIT_IMAGE[i].
- R2: With ir_write high, the instruction register loads the memory word at the selected address on the clock edge. The opcode output always shows IR[31:26].
- R3: alu_src_a set to 0 selects the PC as the first ALU operand; set to 1 it selects register A.
- R4: alu_src_b selects the second ALU operand: 0 is register B, 1 is the constant 4, 2 is IR[15:0] sign-extended, and 3 is that sign-extended value shifted left by two.
- R5: alu_op 0 adds and alu_op 1 subtracts. alu_op 2 decodes IR[5:0]: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than; any other code adds. zero is high when the ALU result is all zeros.
- R6: On every clock, A loads the register named by IR[25:21], B loads the register named by IR[20:16], the ALU result register loads the ALU output, and the memory data register loads the memory word at the current address.
- R7: The memory address is the PC when i_or_d is 0 and the ALU result register when it is 1. Memory is word addressed through address bits [7:2] for 64 words. With mem_write high, the word at that address takes register B.
- R8: With reg_write high, the register file writes the entry at IR[15:11] when reg_dst is 1 and at IR[20:16] when reg_dst is 0. The data is the ALU result register when mem_to_reg is 0 and the memory data register when it is 1.
- R9: Register 0 always reads as zero; writes to it are discarded.
- R10: pc_source 0 loads the PC from the live ALU output, 1 loads it from the ALU result register, and 2 loads the jump target, which is PC[31:28] followed by IR[25:0] and two zero bits.
- R11: The PC updates when pc_write is high, or when pc_write_cond is high and zero is high. Otherwise it holds.
- R12: With ir_write low, the instruction register and the opcode output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_write | input | 1 | Unconditional PC load |
| pc_write_cond | input | 1 | PC load qualified by zero |
| i_or_d | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_write | input | 1 | Store register B to memory |
| ir_write | input | 1 | Load instruction register |
| reg_dst | input | 1 | Write index select: 1 IR[15:11], 0 IR[20:16] |
| mem_to_reg | input | 1 | Write data select: 1 memory data register, 0 ALU result register |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | First ALU operand select |
| alu_src_b | input | 2 | Second ALU operand select |
| alu_op | input | 2 | ALU mode: add, sub, funct-decoded |
| pc_source | input | 2 | PC next-value select |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | ALU result equals zero |
| pc | output | 32 | Current PC |
| alu_out | output | 32 | ALU result register |

## Verification
The hardest case to reach is the conditional PC load. It only means something once earlier cycles have filled A and B from a decoded instruction and stored the branch target in the ALU result register. Until then, a wrong choice between the live ALU output and the stored target cannot be seen. The bench therefore acts as the control sequencer and runs a complete program through the datapath. The program contains one branch that is not taken, one forward branch that is taken, and one backward branch whose negative offset checks the sign extension and shift. Writes to register 0 and signed set-less-than on a negative operand appear only after loads have placed known values in the register file, so every arithmetic result can be predicted.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
   localparam logic [1:0] MODE_ADD   = 2'd0;
   localparam logic [1:0] MODE_SUB   = 2'd1;
   localparam logic [1:0] MODE_FUNCT = 2'd2;

   localparam logic [1:0] OPB_REG    = 2'd0;
   localparam logic [1:0] OPB_FOUR   = 2'd1;
   localparam logic [1:0] OPB_IMM    = 2'd2;
   localparam logic [1:0] OPB_IMM_SH = 2'd3;

   localparam logic [1:0] NPC_LIVE   = 2'd0;
   localparam logic [1:0] NPC_HELD   = 2'd1;
   localparam logic [1:0] NPC_JUMP   = 2'd2;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [1:0]      mode,
   input  logic [5:0]      funct,
   output logic [XLEN-1:0] res,
   output logic            is_zero
);
   logic [XLEN-1:0] sum_w, dif_w, lt_w;

   always_comb begin
      sum_w = opa + opb;
      dif_w = opa - opb;
      lt_w  = ($signed(opa) < $signed(opb)) ? XLEN'(1) : '0;
      res   = sum_w;
      if (mode == MODE_SUB) begin
         res = dif_w;
      end else if (mode == MODE_FUNCT) begin
         case (funct)
            FN_SUB:  res = dif_w;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_SLT:  res = lt_w;
            default: res = sum_w;
         endcase
      end
   end

   assign is_zero = (res == '0);
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
   parameter int XLEN = 32,
   parameter int REGS = 32,
   localparam int RIW = $clog2(REGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RIW-1:0]  rd_a_idx,
   input  logic [RIW-1:0]  rd_b_idx,
   input  logic [RIW-1:0]  wr_idx,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] rd_a_data,
   output logic [XLEN-1:0] rd_b_data
);
   logic [XLEN-1:0] bank_q [REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < REGS; k++) bank_q[k] <= '0;
      end else if (wr_en && wr_idx != '0) begin
         bank_q[wr_idx] <= wr_data;
      end
   end

   assign rd_a_data = (rd_a_idx == '0) ? '0 : bank_q[rd_a_idx];
   assign rd_b_data = (rd_b_idx == '0) ? '0 : bank_q[rd_b_idx];

   // R8
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != '0) |=> bank_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/mc_memory.sv
`timescale 1ns/1ps
module mc_memory #(
   parameter int XLEN  = 32,
   parameter int WORDS = 64,
   parameter logic [XLEN-1:0] INIT_IMAGE [WORDS] = '{default: '0},
   localparam int IW = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] addr,
   input  logic            we,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);
   logic [XLEN-1:0] cell_q [WORDS];
   logic [IW-1:0]   idx;

   assign idx = addr[IW+1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < WORDS; k++) cell_q[k] <= INIT_IMAGE[k];
      end else if (we) begin
         cell_q[idx] <= wdata;
      end
   end

   assign rdata = cell_q[idx];

   // R7
   store_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> cell_q[$past(idx)] == $past(wdata));
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
   import mc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int REGS      = 32,
   parameter int MEM_WORDS = 64,
   parameter logic [XLEN-1:0] INIT_IMAGE [MEM_WORDS] = '{default: '0}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pc_write,
   input  logic            pc_write_cond,
   input  logic            i_or_d,
   input  logic            mem_write,
   input  logic            ir_write,
   input  logic            reg_dst,
   input  logic            mem_to_reg,
   input  logic            reg_write,
   input  logic            alu_src_a,
   input  logic [1:0]      alu_src_b,
   input  logic [1:0]      alu_op,
   input  logic [1:0]      pc_source,
   output logic [5:0]      opcode,
   output logic            zero,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] alu_out
);
   localparam int RIW = $clog2(REGS);
   localparam int MIW = $clog2(MEM_WORDS);

   initial begin : param_chk
      assert (XLEN == 32) else $fatal(1, "instruction fields need XLEN 32");
      assert (RIW == 5 && REGS == 32) else $fatal(1, "register fields are 5 bits");
      assert (MEM_WORDS == (1 << MIW) && MIW >= 1) else $fatal(1, "memory depth must be a power of two");
   end

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
   logic [XLEN-1:0] rf_a, rf_b, mem_rd, mem_addr;
   logic [XLEN-1:0] imm_ext, opa_w, opb_w, alu_y, jump_tgt, pc_nxt, wb_data;
   logic [RIW-1:0]  wb_idx;
   logic            pc_load;

   assign imm_ext  = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
   assign jump_tgt = {pc_q[XLEN-1 -: 4], ir_q[25:0], 2'b00};
   assign mem_addr = i_or_d ? res_q : pc_q;
   assign wb_idx   = reg_dst ? ir_q[15:11] : ir_q[20:16];
   assign wb_data  = mem_to_reg ? mdr_q : res_q;
   assign opa_w    = alu_src_a ? a_q : pc_q;

   always_comb begin
      case (alu_src_b)
         OPB_REG:  opb_w = b_q;
         OPB_FOUR: opb_w = XLEN'(4);
         OPB_IMM:  opb_w = imm_ext;
         default:  opb_w = imm_ext << 2;
      endcase
   end

   always_comb begin
      case (pc_source)
         NPC_LIVE: pc_nxt = alu_y;
         NPC_HELD: pc_nxt = res_q;
         default:  pc_nxt = jump_tgt;
      endcase
   end

   assign pc_load = pc_write | (pc_write_cond & zero);

   mc_alu #(.XLEN(XLEN)) u_alu (
      .opa(opa_w), .opb(opb_w), .mode(alu_op), .funct(ir_q[5:0]),
      .res(alu_y), .is_zero(zero)
   );

   mc_regfile #(.XLEN(XLEN), .REGS(REGS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(ir_q[25:21]), .rd_b_idx(ir_q[20:16]),
      .wr_idx(wb_idx), .wr_en(reg_write), .wr_data(wb_data),
      .rd_a_data(rf_a), .rd_b_data(rf_b)
   );

   mc_memory #(.XLEN(XLEN), .WORDS(MEM_WORDS), .INIT_IMAGE(INIT_IMAGE)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr(mem_addr), .we(mem_write),
      .wdata(b_q), .rdata(mem_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ir_q  <= '0;
         mdr_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
      end else begin
         if (pc_load)  pc_q <= pc_nxt;
         if (ir_write) ir_q <= mem_rd;
         mdr_q <= mem_rd;
         a_q   <= rf_a;
         b_q   <= rf_b;
         res_q <= alu_y;
      end
   end

   assign opcode  = ir_q[31:26];
   assign pc      = pc_q;
   assign alu_out = res_q;

   // R9
   a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q[25:21] == '0) |=> a_q == '0);
   // R11
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_write && !(pc_write_cond && zero)) |=> $stable(pc_q));
   // R12
   ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_write |=> $stable(ir_q));
   // R10
   br_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_write_cond && zero && !pc_write && pc_source == NPC_HELD)
      |=> pc_q == $past(res_q));
   // R4
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_write && pc_source == NPC_LIVE && !alu_src_a &&
       alu_src_b == OPB_FOUR && alu_op == MODE_ADD)
      |=> pc_q == $past(pc_q) + XLEN'(4));
endmodule

// File: tb/mc_datapath_test.sv
`timescale 1ns/1ps
module mc_datapath_test;
   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
      return {op, tgt};
   endfunction

   localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04, OP_J = 6'h02;

   localparam logic [31:0] IMG [64] = '{
      0:  enc_i(OP_LW, 0, 1, 16'd128),
      1:  enc_i(OP_LW, 0, 2, 16'd132),
      2:  enc_i(OP_LW, 0, 9, 16'd136),
      3:  enc_r(1, 2, 3, 6'h20),
      4:  enc_r(1, 2, 4, 6'h22),
      5:  enc_r(1, 2, 5, 6'h24),
      6:  enc_r(1, 2, 6, 6'h25),
      7:  enc_r(2, 1, 7, 6'h2A),
      8:  enc_r(1, 2, 8, 6'h2A),
      9:  enc_r(9, 1, 10, 6'h2A),
      10: enc_i(OP_SW, 0, 3, 16'd140),
      11: enc_i(OP_LW, 0, 11, 16'd140),
      12: enc_r(11, 6, 12, 6'h20),
      13: enc_r(1, 2, 0, 6'h20),
      14: enc_r(0, 1, 13, 6'h20),
      15: enc_i(OP_BEQ, 1, 2, 16'd5),
      16: enc_i(OP_BEQ, 3, 11, 16'd3),
      20: enc_j(OP_J, 26'd24),
      24: enc_r(9, 1, 14, 6'h22),
      25: enc_i(OP_SW, 3, 1, 16'hFFFC),
      26: enc_i(OP_LW, 3, 16, 16'hFFFC),
      27: enc_r(16, 2, 17, 6'h20),
      28: enc_i(OP_BEQ, 0, 0, 16'hFFF6),
      32: 32'd25,
      33: 32'd7,
      34: 32'hFFFF_FFFD,
      default: 32'h0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pc_write, pc_write_cond, i_or_d, mem_write, ir_write;
   logic reg_dst, mem_to_reg, reg_write, alu_src_a;
   logic [1:0] alu_src_b, alu_op, pc_source;
   logic [5:0] opcode;
   logic zero;
   logic [31:0] pc, alu_out;

   int tests_run = 0;
   int tests_bad = 0;
   bit finished = 1'b0;
   logic [31:0] exp_pc = 32'h0;

   always #2.5 clk = ~clk;

   mc_datapath #(.INIT_IMAGE(IMG)) uut (
      .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
      .i_or_d(i_or_d), .mem_write(mem_write), .ir_write(ir_write), .reg_dst(reg_dst),
      .mem_to_reg(mem_to_reg), .reg_write(reg_write), .alu_src_a(alu_src_a),
      .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_source(pc_source),
      .opcode(opcode), .zero(zero), .pc(pc), .alu_out(alu_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      pc_write = 0; pc_write_cond = 0; i_or_d = 0; mem_write = 0; ir_write = 0;
      reg_dst = 0; mem_to_reg = 0; reg_write = 0; alu_src_a = 0;
      alu_src_b = 2'd0; alu_op = 2'd0; pc_source = 2'd0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      idle();
   endtask

   // fetch then decode; decode leaves PC+4 + (imm<<2) in alu_out
   task automatic fetch_decode(input logic [5:0] eop);
      ir_write = 1; pc_write = 1; alu_src_b = 2'd1;
      tick();
      chk("R2 opcode", {26'd0, opcode}, {26'd0, eop});
      chk("R10 pc+4", pc, exp_pc + 32'd4);
      chk("R3 alu_out pc+4", alu_out, exp_pc + 32'd4);
      exp_pc = exp_pc + 32'd4;
      alu_src_b = 2'd3;
      tick();
   endtask

   task automatic do_r(input logic [31:0] exp, input string req);
      fetch_decode(OP_R);
      alu_src_a = 1; alu_op = 2'd2;
      tick();
      chk(req, alu_out, exp);
      reg_dst = 1; reg_write = 1;
      tick();
   endtask

   task automatic do_addr(input logic [5:0] op, input logic [31:0] ea);
      fetch_decode(op);
      alu_src_a = 1; alu_src_b = 2'd2;
      tick();
      chk("R4 effective address", alu_out, ea);
   endtask

   task automatic do_lw(input logic [31:0] ea);
      do_addr(OP_LW, ea);
      i_or_d = 1;
      tick();
      mem_to_reg = 1; reg_write = 1;
      tick();
   endtask

   task automatic do_sw(input logic [31:0] ea);
      do_addr(OP_SW, ea);
      i_or_d = 1; mem_write = 1;
      tick();
   endtask

   task automatic do_beq(input logic [31:0] tgt, input bit taken);
      fetch_decode(OP_BEQ);
      chk("R4 branch target", alu_out, tgt);
      alu_src_a = 1; alu_op = 2'd1; pc_write_cond = 1; pc_source = 2'd1;
      #1;
      chk("R5 zero flag", {31'd0, zero}, {31'd0, taken});
      tick();
      if (taken) exp_pc = tgt;
      chk("R11 branch pc", pc, exp_pc);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset pc", pc, 32'h0);
      chk("R1 reset ir", {26'd0, opcode}, 32'h0);
      chk("R1 reset alu_out", alu_out, 32'h0);
      rst_n = 1'b1;

      do_lw(32'd128);                       // R7 R8 load path
      do_lw(32'd132);
      do_lw(32'd136);
      do_r(32'd32, "R5 add");
      do_r(32'd18, "R5 sub");
      do_r(32'd1,  "R5 and");
      do_r(32'd31, "R5 or");
      do_r(32'd1,  "R5 slt true");
      do_r(32'd0,  "R5 slt false");
      do_r(32'd1,  "R5 slt signed");
      do_sw(32'd140);
      do_lw(32'd140);
      do_r(32'd63, "R7 R8 stored value reloaded");
      do_r(32'd32, "R9 write target r0");
      do_r(32'd25, "R9 r0 reads zero");
      do_beq(32'd84, 1'b0);                 // R11 not taken
      do_beq(32'd80, 1'b1);                 // R10 taken forward

      fetch_decode(OP_J);
      pc_write = 1; pc_source = 2'd2;
      tick();
      exp_pc = 32'd96;
      chk("R10 jump target", pc, exp_pc);

      do_r(32'hFFFF_FFE4, "R5 sub negative");
      do_sw(32'd28);                        // R4 negative offset
      do_lw(32'd28);
      do_r(32'd32, "R6 R8 negative-offset round trip");
      do_beq(32'd76, 1'b1);                 // R4 backward offset

      // R12 R11: nothing enabled, IR and PC hold though memory at PC differs
      pc_write_cond = 1; alu_src_b = 2'd1;
      tick();
      chk("R12 ir hold", {26'd0, opcode}, {26'd0, OP_BEQ});
      chk("R11 pc hold", pc, 32'd76);

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         tests_run++;
         tests_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
         $finish;
      end
   end
endmodule